// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers asynchronous serial characters from a single line. The line rests high. A character opens with a low start bit, carries 7 or 8 data bits with the least significant bit first, may carry a parity bit, and closes with a high stop period. The block runs from the system clock. A one-clock enable pulse, `tick`, arrives sixteen times per bit period and paces all of its timing. The block does not generate the bit rate.

The line first passes through a two-flop synchroniser. A high-to-low transition seen while the receiver is idle restarts a four-bit oversample counter. Each bit is read at the eighth tick of its sixteen-tick slot, which is its centre. If the start bit has already returned high at its centre, the event is treated as noise and dropped. At the centre of the first stop bit the character is presented on `data_out` together with a one-clock `data_valid` strobe. Status flags for a parity mismatch and a low stop level are presented with it. An interrupt request rises at the same time and stays high until the processor acknowledges it.

The data width, the parity mode and the stop length are static inputs. They change only while the line is idle.

Top module: `uart_os_rx`

## Requirements
- R1: After reset `data_out`, `data_valid`, `parity_err`, `frame_err` and `irq` are all 0, and they stay 0 while the line stays high.
- R2: `rx` passes through two synchronising flops. A character starts only on a high-to-low transition of the synchronised line seen while idle. A line that is already low when idle is entered does not start one.
- R3: Each bit occupies 16 `tick` pulses counted from the start transition, and it is sampled on the 8th pulse of its slot. Data bits arrive least significant bit first.
- R4: With `cfg_data7`=1 the character has 7 data bits and `data_out[7]` is 0. With `cfg_data7`=0 it has 8 data bits.
- R5: With `cfg_par_en`=1 one parity bit follows the data. `cfg_par_odd`=1 requires an odd count of ones over the data and parity bits, and `cfg_par_odd`=0 requires an even count. A mismatch sets `parity_err` with the character. With `cfg_par_en`=0 no parity bit is expected and `parity_err` is 0.
- R6: At the centre sample of the first stop bit, `data_valid` is high for exactly one clock, with `data_out` and the flags. `frame_err` is 1 when that sample is low and 0 when it is high. The character is delivered in both cases.
- R7: A synchronised line that is high at the centre sample of the start bit returns the receiver to idle with no output.
- R8: `cfg_stop` encodes the stop length: 00 is 1 bit, 01 is 1.5 bits and 10 or 11 is 2 bits. After the first stop centre the receiver ignores start transitions for 0, 8 or 16 further ticks respectively.
- R9: `irq` rises with `data_valid` and holds until a cycle with `irq_ack`=1. When a new character arrives in the same cycle as the acknowledge, the set wins.
- R10: Bit timing advances only on cycles with `tick`=1. Stalling `tick` stretches the character without corrupting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-clock enable at 16 times the bit rate |
| rx | input | 1 | Asynchronous serial line, idle high |
| cfg_data7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 expects a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop | input | 2 | Stop length: 00 is 1, 01 is 1.5, 1x is 2 bits |
| irq_ack | input | 1 | Clears the interrupt request |
| data_out | output | 8 | Last received character |
| data_valid | output | 1 | One-clock strobe when a character completes |
| parity_err | output | 1 | Parity mismatch on the last character |
| frame_err | output | 1 | Low first stop bit on the last character |
| irq | output | 1 | Receive-full interrupt request |

## Verification
The characters sent include alternating, all-zero and all-one bytes and bytes of uneven weight, in all four combinations of data width and parity. These show up bit-order and width mistakes and tell correct parity apart from a flipped parity bit. Some frames have a forced low stop bit, which separates a framing fault from a parity fault. A three-tick low pulse is sent to test start validation. A low pulse inside the two-bit stop period tests the guard window. A character sent with a variable tick cadence and a long tick stall shows that only enable pulses, and not clocks, move the bit timing.

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int OVERSAMPLE = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx,
  input  logic          cfg_data7,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic [1:0]    cfg_stop,
  input  logic          irq_ack,
  output logic [DW-1:0] data_out,
  output logic          data_valid,
  output logic          parity_err,
  output logic          frame_err,
  output logic          irq
);
  localparam int CW   = $clog2(OVERSAMPLE);
  localparam int GW   = CW + 1;
  localparam int BW   = $clog2(DW + 4);
  localparam int IW   = $clog2(DW);
  localparam int HALF = OVERSAMPLE / 2;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_RECV = 2'd1, S_GUARD = 2'd2} st_t;

  st_t            state;
  logic [1:0]     sync;
  logic           prev;
  logic [CW-1:0]  cnt;
  logic [GW-1:0]  gcnt;
  logic [BW-1:0]  bitn;
  logic [DW-1:0]  dbuf;
  logic           pbit;

  wire line = sync[1];
  wire fall = prev & ~line;
  wire mid  = tick && (cnt == CW'(HALF - 1));

  wire [BW-1:0] nd       = cfg_data7 ? BW'(DW - 1) : BW'(DW);
  wire [BW-1:0] stop_idx = nd + BW'(1) + BW'(cfg_par_en);
  wire [GW-1:0] glen     = (cfg_stop == 2'b00) ? GW'(0) :
                           (cfg_stop == 2'b01) ? GW'(HALF) : GW'(OVERSAMPLE);

  wire in_recv  = (state == S_RECV);
  wire glitch   = in_recv && mid && (bitn == '0) && line;
  wire deliver  = in_recv && mid && (bitn != '0) && (bitn == stop_idx);
  wire take_dat = in_recv && mid && (bitn != '0) && (bitn <= nd);
  wire take_par = in_recv && mid && (bitn > nd) && (bitn != stop_idx);
  wire perr     = cfg_par_en & (^dbuf ^ pbit ^ cfg_par_odd);
  wire [IW-1:0] widx = IW'(bitn - BW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      prev <= 1'b1;
    end else begin
      sync <= {sync[0], rx};
      prev <= line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      gcnt  <= '0;
      bitn  <= '0;
      dbuf  <= '0;
      pbit  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (fall) begin
          state <= S_RECV;
          cnt   <= '0;
          bitn  <= '0;
          dbuf  <= '0;
        end
        S_RECV: if (tick) begin
          if (cnt == CW'(OVERSAMPLE - 1)) begin
            cnt  <= '0;
            bitn <= bitn + BW'(1);
          end else begin
            cnt <= cnt + CW'(1);
          end
          if (glitch) state <= S_IDLE;
          if (take_dat) dbuf[widx] <= line;
          if (take_par) pbit <= line;
          if (deliver) begin
            gcnt  <= '0;
            state <= (glen == '0) ? S_IDLE : S_GUARD;
          end
        end
        S_GUARD: if (tick) begin
          gcnt <= gcnt + GW'(1);
          if (gcnt == glen - GW'(1)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out   <= '0;
      data_valid <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      irq        <= 1'b0;
    end else begin
      data_valid <= deliver;
      irq        <= (irq & ~irq_ack) | deliver;
      if (deliver) begin
        data_out   <= dbuf;
        parity_err <= perr;
        frame_err  <= ~line;
      end
    end
  end
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int CW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          irq_ack,
  input logic          cfg_data7,
  input logic          cfg_par_en,
  input logic [DW-1:0] data_out,
  input logic          data_valid,
  input logic          parity_err,
  input logic          irq,
  input logic [1:0]    state,
  input logic [CW-1:0] cnt
);
  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);
  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> irq);
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
  // R5
  par_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !cfg_par_en) |-> !parity_err);
  // R4
  seven_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && cfg_data7) |-> !data_out[DW-1]);
  // R10
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && !tick) |=> $stable(cnt));
  // R8
  guard_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2) |=> (state != 2'd1));
endmodule

bind uart_os_rx uart_os_rx_chk #(.CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .irq_ack(irq_ack),
  .cfg_data7(cfg_data7), .cfg_par_en(cfg_par_en),
  .data_out(data_out), .data_valid(data_valid), .parity_err(parity_err),
  .irq(irq), .state(state), .cnt(cnt)
);

// File: tb/sim_uart_os_rx.sv
`timescale 1ns/1ps
module sim_uart_os_rx;
  logic clk = 0, rst_n = 0, tick = 0, rx = 1;
  logic cfg_data7 = 0, cfg_par_en = 0, cfg_par_odd = 0, irq_ack = 0;
  logic [1:0] cfg_stop = 2'b00;
  logic [7:0] data_out;
  logic data_valid, parity_err, frame_err, irq;

  always #10 clk = ~clk;

  uart_os_rx u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx),
    .cfg_data7(cfg_data7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop(cfg_stop), .irq_ack(irq_ack), .data_out(data_out),
    .data_valid(data_valid), .parity_err(parity_err), .frame_err(frame_err), .irq(irq));

  int nchk = 0, nerr = 0, ncyc = 0;
  int tper = 4, div = 0;
  bit tick_en = 1;

  always @(negedge clk) begin
    if (!rst_n) begin div = 0; tick <= 0; end
    else if (tick_en && div >= tper - 1) begin tick <= 1; div = 0; end
    else begin tick <= 0; if (tick_en) div++; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: tick count since the start edge, sampled at slot centre
  bit m1 = 1, m2 = 1, m3 = 1, mline, mprv, mdeliv, mp;
  int mmode = 0, mt = 0, mg = 0, mglen = 0, mb, mnd, msidx;
  bit [7:0] mdat, e_data;
  bit e_valid, e_perr, e_ferr, e_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 = 1; m2 = 1; m3 = 1; mmode = 0; mt = 0; mg = 0; mp = 0; mdat = 0;
      e_data = 0; e_valid = 0; e_perr = 0; e_ferr = 0; e_irq = 0;
    end else begin
      mline = m2; mprv = m3; m3 = m2; m2 = m1; m1 = rx;
      mnd = cfg_data7 ? 7 : 8;
      msidx = mnd + 1 + int'(cfg_par_en);
      mdeliv = 0; e_valid = 0;
      if (mmode == 0) begin
        if (mprv && !mline) begin mmode = 1; mt = 0; mdat = 0; end
      end else if (mmode == 1) begin
        if (tick) begin
          mt++;
          if (mt % 16 == 8) begin
            mb = mt / 16;
            if (mb == 0) begin
              if (mline) mmode = 0;
            end else if (mb <= mnd) mdat[mb-1] = mline;
            else if (mb == msidx) begin
              e_data = mdat; e_valid = 1; e_ferr = !mline; mdeliv = 1;
              e_perr = cfg_par_en && (^mdat ^ mp ^ cfg_par_odd);
              mglen = (cfg_stop == 0) ? 0 : (cfg_stop == 1) ? 8 : 16;
              if (mglen == 0) mmode = 0; else begin mmode = 2; mg = 0; end
            end else mp = mline;
          end
        end
      end else if (tick) begin
        mg++;
        if (mg == mglen) mmode = 0;
      end
      e_irq = (e_irq && !irq_ack) || mdeliv;
    end
  end

  int nvalid = 0;
  bit [7:0] cap_data;
  bit cap_perr, cap_ferr;

  always @(negedge clk) begin
    if (rst_n) begin
      ncyc++;
      chk(data_out == e_data, "R3 R4 data_out", data_out, e_data);
      chk(data_valid == e_valid, "R2 R7 R10 data_valid", data_valid, e_valid);
      chk(parity_err == e_perr, "R5 parity_err", parity_err, e_perr);
      chk(frame_err == e_ferr, "R6 frame_err", frame_err, e_ferr);
      chk(irq == e_irq, "R9 irq", irq, e_irq);
      if (data_valid) begin
        nvalid++; cap_data = data_out; cap_perr = parity_err; cap_ferr = frame_err;
      end
    end
  end

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick);
    end
    @(negedge clk);
  endtask

  task automatic send(input bit [7:0] d, input bit flip, input bit bad_stop,
                      input int hi_ticks, input int low_ticks);
    int nd, n0;
    bit p;
    bit [7:0] expd;
    nd = cfg_data7 ? 7 : 8;
    expd = cfg_data7 ? {1'b0, d[6:0]} : d;
    n0 = nvalid;
    rx = 0; wait_ticks(16);
    for (int i = 0; i < nd; i++) begin rx = d[i]; wait_ticks(16); end
    if (cfg_par_en) begin
      p = (^expd) ^ cfg_par_odd ^ flip;
      rx = p; wait_ticks(16);
    end
    if (bad_stop) begin rx = 0; wait_ticks(16); end
    rx = 1; wait_ticks(hi_ticks);
    if (low_ticks > 0) begin rx = 0; wait_ticks(low_ticks); rx = 1; end
    wait_ticks(24);
    chk(nvalid == n0 + 1, "R6 one strobe per character", nvalid - n0, 1);
    chk(cap_data == expd, "R3 R4 character", cap_data, expd);
    chk(cap_perr == (cfg_par_en & flip), "R5 parity flag", cap_perr, cfg_par_en & flip);
    chk(cap_ferr == bad_stop, "R6 framing flag", cap_ferr, bad_stop);
  endtask

  task automatic setcfg(input bit d7, input bit pe, input bit po, input bit [1:0] st);
    @(negedge clk);
    cfg_data7 = d7; cfg_par_en = pe; cfg_par_odd = po; cfg_stop = st;
    wait_ticks(4);
  endtask

  int n0;
  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (40) @(negedge clk);
    chk(data_out == 0 && !data_valid && !parity_err && !frame_err && !irq,
        "R1 idle outputs", {data_out, data_valid, irq}, 0);
    chk(nvalid == 0, "R1 no strobe while line high", nvalid, 0);

    setcfg(0, 0, 0, 2'b00);
    send(8'hA5, 0, 0, 16, 0);
    send(8'h3C, 0, 0, 16, 0);
    send(8'h00, 0, 0, 16, 0);
    send(8'hFF, 0, 0, 16, 0);

    setcfg(0, 1, 0, 2'b00);
    send(8'h5A, 0, 0, 16, 0);
    send(8'h5B, 1, 0, 16, 0);
    setcfg(0, 1, 1, 2'b01);
    send(8'h81, 0, 0, 24, 0);
    send(8'h80, 1, 0, 24, 0);
    setcfg(1, 1, 0, 2'b00);
    send(8'hD3, 0, 0, 16, 0);
    send(8'h2E, 1, 0, 16, 0);
    setcfg(1, 1, 1, 2'b10);
    send(8'h7F, 0, 0, 32, 0);
    setcfg(1, 0, 0, 2'b00);
    send(8'hF1, 0, 0, 16, 0);

    setcfg(0, 0, 0, 2'b00);
    send(8'h66, 0, 1, 16, 0);
    setcfg(0, 1, 0, 2'b00);
    send(8'h99, 1, 1, 16, 0);

    chk(irq == 1, "R9 irq held without ack", irq, 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0; @(negedge clk);
    chk(irq == 0, "R9 irq cleared by ack", irq, 0);

    n0 = nvalid;
    rx = 0; wait_ticks(3); rx = 1; wait_ticks(48);
    chk(nvalid == n0, "R7 short low pulse ignored", nvalid - n0, 0);
    chk(irq == 0, "R7 no irq from glitch", irq, 0);

    setcfg(0, 0, 0, 2'b10);
    n0 = nvalid;
    send(8'hC4, 0, 0, 12, 20);
    chk(nvalid == n0 + 1, "R8 edge inside guard ignored", nvalid - n0, 1);

    setcfg(0, 0, 0, 2'b00);
    tper = 3;
    n0 = nvalid;
    fork
      send(8'h4D, 0, 0, 16, 0);
      begin repeat (300) @(negedge clk); tick_en = 0; repeat (90) @(negedge clk); tick_en = 1; end
    join
    chk(cap_data == 8'h4D && nvalid == n0 + 1, "R10 stalled tick character", cap_data, 8'h4D);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=%0d expected=done", ncyc);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule